// File: doc/BRIEF.md
# Serial Wiper Step Engine

This block drives the fine-tuning phase of a dual-wiper serial-bus potentiometer controller. Once the command decoder has acknowledged a step instruction, it pulses `arm_i` with the chosen wiper index and that wiper's present 6-bit position. From then on the bus carries no bytes. Each SCL clock pulse moves the wiper by one tap, and the level of SDA during the pulse gives the direction. SDA high moves the wiper up, toward the high resistor end. SDA low moves it down, toward the low end.

The block reads the bus lines after they have been synchronised to `clk`. It samples SDA when SCL rises and commits the step when SCL falls. A change on SDA while SCL is high is a bus START or STOP. Either one ends the mode and discards the step that was waiting. Each committed step produces a one-cycle `upd_o` strobe, together with the new value and the wiper index, so the register engine can write its volatile wiper register. The block touches no stored settings and never drives the bus.

Top module: `wiper_stepper`

## Requirements
- R1: After reset, `active_o` is 0, `upd_o` is 0 and `upd_val_o` is 0.
- R2: A cycle with `arm_i` high loads `arm_val_i` into `upd_val_o` and `arm_sel_i` into `upd_sel_o`, and sets `active_o` to 1 in the following cycle. No strobe is issued for the arm itself.
- R3: While active, an SCL pulse with SDA high at the SCL rise raises `upd_o` for one cycle. This happens in the cycle after the falling SCL is seen, and `upd_val_o` then holds the old value plus one.
- R4: While active, an SCL pulse with SDA low at the SCL rise strobes `upd_o` with `upd_val_o` equal to the old value minus one, using the same timing as R3.
- R5: A step up from 63 leaves the value at 63, and a step down from 0 leaves it at 0. There is no wrap-around, and the strobe is still issued.
- R6: SDA rising while SCL is high (STOP) clears `active_o` and cancels any pending step, so no strobe follows.
- R7: SDA falling while SCL is high (START) clears `active_o` and cancels any pending step, so no strobe follows.
- R8: While `active_o` is 0, SCL pulses produce no strobe and leave `upd_val_o` unchanged.
- R9: Up and down pulses may be mixed freely in one session, and each SCL pulse gives at most one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data |
| arm_i | input | 1 | One-cycle pulse that enters step mode |
| arm_sel_i | input | SEL_W | Wiper selected by the instruction |
| arm_val_i | input | VAL_W | Current position of the selected wiper |
| active_o | output | 1 | Step mode is in progress |
| upd_o | output | 1 | One-cycle strobe: write `upd_val_o` to the wiper |
| upd_sel_o | output | SEL_W | Wiper index for the write |
| upd_val_o | output | VAL_W | New wiper position |

## Verification
The bound checker watches several properties on every cycle. It checks that an arm loads the value without a strobe and that strobes never come in back-to-back cycles. It checks that each strobe moves the value by exactly one tap, or by none only at an end stop. It checks that no strobe appears outside the mode and that a bus condition while SCL is high ends the mode. Some behaviour needs a bus history that only the bench's scenarios supply: the direction follows SDA as sampled at the rise, a step is cancelled when a START or STOP interrupts its pulse, and pulses are dead after exit. The bench sweeps every start value on both wipers, with up and down steps, and computes the saturated results arithmetically.

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int VAL_W = 6,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             arm_i,
  input  logic [SEL_W-1:0] arm_sel_i,
  input  logic [VAL_W-1:0] arm_val_i,
  output logic             active_o,
  output logic             upd_o,
  output logic [SEL_W-1:0] upd_sel_o,
  output logic [VAL_W-1:0] upd_val_o
);
  localparam logic [VAL_W-1:0] TOP = {VAL_W{1'b1}};

  logic             scl_q, sda_q, pend, dir;
  logic [VAL_W-1:0] val, nxt;
  logic [SEL_W-1:0] sel;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire bus_cond = scl_i & scl_q & (sda_i ^ sda_q);

  assign nxt = dir ? ((val == TOP) ? val : val + 1'b1)
                   : ((val == '0)  ? val : val - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      active_o <= 1'b0;
      pend     <= 1'b0;
      dir      <= 1'b0;
      upd_o    <= 1'b0;
      val      <= '0;
      sel      <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      upd_o <= 1'b0;
      if (arm_i) begin
        active_o <= 1'b1;
        pend     <= 1'b0;
        val      <= arm_val_i;
        sel      <= arm_sel_i;
      end else if (active_o) begin
        if (bus_cond) begin
          active_o <= 1'b0;
          pend     <= 1'b0;
        end else if (scl_rise) begin
          pend <= 1'b1;
          dir  <= sda_i;
        end else if (scl_fall && pend) begin
          pend  <= 1'b0;
          upd_o <= 1'b1;
          val   <= nxt;
        end
      end
    end
  end

  assign upd_val_o = val;
  assign upd_sel_o = sel;
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int VAL_W = 6,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             arm_i,
  input logic [SEL_W-1:0] arm_sel_i,
  input logic [VAL_W-1:0] arm_val_i,
  input logic             active_o,
  input logic             upd_o,
  input logic [SEL_W-1:0] upd_sel_o,
  input logic [VAL_W-1:0] upd_val_o
);
  localparam logic [VAL_W-1:0] TOP = {VAL_W{1'b1}};
  localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

  a_r2_arm_load: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (active_o && !upd_o && upd_val_o == $past(arm_val_i) && upd_sel_o == $past(arm_sel_i)));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  a_r3_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (upd_val_o == $past(upd_val_o) + ONE || upd_val_o == $past(upd_val_o) - ONE
               || upd_val_o == $past(upd_val_o)));

  a_r5_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && upd_val_o == $past(upd_val_o)) |-> (upd_val_o == '0 || upd_val_o == TOP));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !arm_i) |=> (!upd_o && $stable(upd_val_o)));

  a_r6_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !arm_i && scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !active_o);

  a_r7_start_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !arm_i && scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !active_o);
endmodule

bind wiper_stepper wiper_stepper_chk #(.VAL_W(VAL_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .arm_i(arm_i),
  .arm_sel_i(arm_sel_i), .arm_val_i(arm_val_i), .active_o(active_o),
  .upd_o(upd_o), .upd_sel_o(upd_sel_o), .upd_val_o(upd_val_o));

// File: tb/wiper_stepper_tb_top.sv
module wiper_stepper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, arm = 1'b0;
  logic [0:0] asel = '0;
  logic [5:0] aval = '0;
  logic       active, upd;
  logic [0:0] usel;
  logic [5:0] uval;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wiper_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .arm_i(arm),
    .arm_sel_i(asel), .arm_val_i(aval), .active_o(active), .upd_o(upd),
    .upd_sel_o(usel), .upd_val_o(uval));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input int s, input int v);
    @(negedge clk); arm = 1'b1; asel = s[0:0]; aval = v[5:0];
    @(negedge clk); arm = 1'b0;
    chk(active === 1'b1 && upd === 1'b0, "R2 active", int'(active), 1);
    chk(uval === v[5:0] && usel === s[0:0], "R2 load", int'(uval), v);
  endtask

  task automatic pulse(input bit d, output bit s1, output bit s2, output int v);
    @(negedge clk); sda = d;
    @(negedge clk); scl = 1'b1;
    repeat (2) @(negedge clk);
    scl = 1'b0;
    @(negedge clk); s1 = upd; v = int'(uval);
    @(negedge clk); s2 = upd;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    bit s1, s2;
    int v, e, cur;
    repeat (3) @(negedge clk);
    chk(active === 1'b0 && upd === 1'b0 && uval === 6'd0, "R1 reset", int'(uval), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: pulses before arming are dead
    pulse(1'b1, s1, s2, v);
    chk(!s1 && !s2 && v == 0, "R8 idle pulse", int'(s1), 0);

    // R3/R4/R5 sweep over both wipers and every start value
    for (int w = 0; w < 2; w++) begin
      for (int st = 0; st < 64; st++) begin
        do_arm(w, st);
        pulse(1'b1, s1, s2, v);
        e = (st == 63) ? 63 : st + 1;
        chk(s1 && !s2, "R3 strobe", int'(s1), 1);
        chk(v == e, (st == 63) ? "R5 top hold" : "R3 up", v, e);
        chk(usel === w[0:0], "R2 sel", int'(usel), w);
        pulse(1'b0, s1, s2, v);
        e = (e == 0) ? 0 : e - 1;
        chk(s1 && !s2, "R4 strobe", int'(s1), 1);
        chk(v == e, "R4 down", v, e);
        if (st == 0) begin
          pulse(1'b0, s1, s2, v);
          chk(s1 && v == 0, "R5 bottom hold", v, 0);
        end
      end
    end

    // R9: mixed sequence
    do_arm(1, 30);
    cur = 30;
    for (int k = 0; k < 20; k++) begin
      bit d = ((k * 7) % 3) != 0;
      pulse(d, s1, s2, v);
      cur = d ? ((cur == 63) ? 63 : cur + 1) : ((cur == 0) ? 0 : cur - 1);
      chk(s1 && !s2 && v == cur, "R9 mixed", v, cur);
    end

    // R6: STOP inside a pending down pulse
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b1;
    @(negedge clk);
    chk(active === 1'b0, "R6 stop exit", int'(active), 0);
    scl = 1'b0;
    @(negedge clk); s1 = upd;
    @(negedge clk);
    chk(!s1 && !upd && uval == cur[5:0], "R6 step dropped", int'(uval), cur);
    pulse(1'b1, s1, s2, v);
    chk(!s1 && !s2 && v == cur, "R8 after stop", v, cur);

    // R7: START inside a pending up pulse
    do_arm(0, 10);
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b0;
    @(negedge clk);
    chk(active === 1'b0, "R7 start exit", int'(active), 0);
    scl = 1'b0;
    @(negedge clk); s1 = upd;
    @(negedge clk);
    chk(!s1 && !upd && uval == 6'd10, "R7 step dropped", int'(uval), 10);
    pulse(1'b0, s1, s2, v);
    chk(!s1 && v == 10, "R8 after start", v, 10);

    finished = 1;
    finish_run();
  end
endmodule